// File: doc/BRIEF.md
# SIMD floating-point control and status register

This block holds the 32-bit control and status word of a SIMD floating-point unit. The word sets the rounding direction, a mask for each exception class, the denormals-are-zero and flush-to-zero modes, and one sticky flag per exception class. Software writes the whole word through a load port and reads it through a store port. A load that would set any reserved bit is refused, and the block raises a general-protection fault request instead.

A trap-evaluation port watches the SIMD operations as they finish. When an operation reports exception classes, the block ORs them into the sticky flags. It raises an exception request when a reported class is unmasked. A load that unmasks a class whose flag is already set raises no request. The trap waits until a later SIMD operation reports that same class.

Bit layout:

| Bits | Field |
|---|---|
| 5:0 | flags: invalid, denormal, divide-by-zero, overflow, underflow, precision |
| 6 | denormals-are-zero |
| 12:7 | masks, in the same order as the flags |
| 14:13 | rounding control |
| 15 | flush-to-zero |
| 31:16 | reserved, always zero |

Top module: `simd_csr`

## Requirements
- R1: While reset is held, and after it is released, the register reads 0x00001F80. All masks are set, all flags are clear, rounding control is 0, and daz and ftz are 0.
- R2: A load whose bits 31:16 are all zero replaces the whole register with the load word at the next clock edge.
- R3: `st_data` shows the current register value combinationally. In a cycle with a load it still shows the old value, and the new value appears in the next cycle.
- R4: A load with any of bits 31:16 set raises `ld_fault` in the same cycle and leaves the register unchanged. Bits 31:16 of the register always read zero.
- R5: `ld_fault` is low in every cycle that has no load, and in every load whose bits 31:16 are zero.
- R6: A reported operation (`op_valid`=1) ORs `op_exc[5:0]` into flag bits 5:0 at the next edge. Bit i of `op_exc` maps to flag bit i. Only a load can clear a flag.
- R7: `exc_req` equals `op_valid` AND (`op_exc` & ~mask bits 12:7) != 0. It is combinational and uses the masks held at the start of the cycle.
- R8: A load that clears a mask bit whose flag is already set raises no `exc_req`. In later cycles `exc_req` stays low until an operation reports that same class with `op_valid`=1.
- R9: `rnd_mode` equals bits 14:13, `daz` equals bit 6 and `ftz` equals bit 15, always taken from the current register.
- R10: When a load and a report fall in the same cycle, the new value is the load word (or the old value if the load faults) with `op_exc` ORed into bits 5:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | asynchronous reset, active low |
| ld_en | input | 1 | load strobe |
| ld_data | input | 32 | load word |
| ld_fault | output | 1 | general-protection fault request for a load that would set a reserved bit |
| st_data | output | 32 | current register value |
| op_valid | input | 1 | a SIMD operation with register operands completes this cycle |
| op_exc | input | 6 | exception classes the operation reports |
| exc_req | output | 1 | request for an unmasked SIMD exception |
| rnd_mode | output | 2 | rounding control |
| daz | output | 1 | denormals-are-zero enable |
| ftz | output | 1 | flush-to-zero enable |

## Verification
The bench goes after the deferred trap. It loads a word that clears a mask over a flag that is already set, then reports other classes and then the matching class. A design that evaluates the flags instead of the reported bits would trap at the load. It also loads words with one reserved bit set at a time; a design that takes such a load would let a nonzero upper half show on the store port. Same-cycle load and report, and same-cycle load and store, are both driven. A design that lets one action override the other would lose sticky flags or expose the new value one cycle early. A random stream is then compared against a behavioural model on every cycle.

// File: rtl/simd_csr.sv
module simd_csr #(
  parameter logic [31:0] RESET_VAL = 32'h0000_1F80
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ld_en,
  input  logic [31:0] ld_data,
  output logic        ld_fault,
  output logic [31:0] st_data,
  input  logic        op_valid,
  input  logic [5:0]  op_exc,
  output logic        exc_req,
  output logic [1:0]  rnd_mode,
  output logic        daz,
  output logic        ftz
);

  logic [15:0] csr_q;
  logic [15:0] base;
  logic        ld_ok;

  assign ld_fault = ld_en && (ld_data[31:16] != 16'h0);
  assign ld_ok    = ld_en && !ld_fault;
  assign base     = ld_ok ? ld_data[15:0] : csr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      csr_q <= RESET_VAL[15:0];
    else if (ld_ok || op_valid)
      csr_q <= {base[15:6], base[5:0] | (op_valid ? op_exc : 6'h0)};
  end

  assign st_data  = {16'h0, csr_q};
  assign exc_req  = op_valid && ((op_exc & ~csr_q[12:7]) != 6'h0);
  assign rnd_mode = csr_q[14:13];
  assign daz      = csr_q[6];
  assign ftz      = csr_q[15];

  // R2
  load_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_en && ld_data[31:16] == 16'h0 && !op_valid) |=> st_data == $past(ld_data));

  // R4
  fault_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_fault && !op_valid) |=> $stable(st_data));

  // R4
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_data[31:16] == 16'h0);

  // R6
  flags_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_en && op_valid) |=> (st_data[5:0] & $past(st_data[5:0] | op_exc)) == $past(st_data[5:0] | op_exc));

  // R7
  req_needs_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> op_valid && op_exc != 6'h0);

  // R5
  fault_needs_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_fault |-> ld_en);

endmodule

// File: tb/simd_csr_test.sv
module simd_csr_test;
  localparam int CLK_NS = 10;

  logic        clk = 0, rst_n = 0;
  logic        ld_en = 0, op_valid = 0;
  logic [31:0] ld_data = 0;
  logic [5:0]  op_exc = 0;
  logic        ld_fault, exc_req, daz, ftz;
  logic [31:0] st_data;
  logic [1:0]  rnd_mode;

  int tests = 0, fails = 0;
  bit done = 0;
  logic [31:0] model;

  simd_csr uut (.clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_data(ld_data),
    .ld_fault(ld_fault), .st_data(st_data), .op_valid(op_valid), .op_exc(op_exc),
    .exc_req(exc_req), .rnd_mode(rnd_mode), .daz(daz), .ftz(ftz));

  always #(CLK_NS/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare(string tag);
    bit bad;
    bit unmasked;
    bad = ld_en && (ld_data[31:16] != 0);
    unmasked = 0;
    for (int i = 0; i < 6; i++)
      if (op_exc[i] && !model[7+i]) unmasked = 1;
    chk({tag, " R3 store"}, st_data, model);
    chk({tag, " R4/R5 fault"}, {31'h0, ld_fault}, {31'h0, bad});
    chk({tag, " R7/R8 req"}, {31'h0, exc_req}, {31'h0, op_valid && unmasked});
    chk({tag, " R9 modes"}, {28'h0, ftz, daz, rnd_mode}, {28'h0, model[15], model[6], model[14:13]});
  endtask

  task automatic step(bit l, logic [31:0] d, bit v, logic [5:0] e, string tag);
    ld_en = l; ld_data = d; op_valid = v; op_exc = e;
    #1;
    compare(tag);
    @(posedge clk);
    if (l && d[31:16] == 0) model = d;
    if (v) model[5:0] = model[5:0] | e;
    @(negedge clk);
    ld_en = 0; op_valid = 0; op_exc = 0; ld_data = 0;
  endtask

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    model = 32'h0000_1F80;
    #(CLK_NS * 2 + 1);
    compare("R1 in reset");
    @(negedge clk); rst_n = 1;
    #1 compare("R1 after reset");
    @(negedge clk);

    step(1, 32'h0000_6040, 0, 0, "R2 load modes");
    step(0, 0, 0, 0, "R2 readback");
    step(1, 32'h0001_0000, 0, 0, "R4 fault bit16");
    step(1, 32'h8000_1F80, 0, 0, "R4 fault bit31");
    step(0, 0, 0, 0, "R4 unchanged");
    step(0, 0, 1, 6'h01, "R7 unmasked report");
    step(0, 0, 1, 6'h20, "R6 second flag");
    step(0, 0, 0, 0, "R6 sticky");
    step(1, 32'h0000_1F81, 0, 0, "R8 masked with flag");
    step(1, 32'h0000_1F01, 0, 0, "R8 unmask over flag");
    step(0, 0, 0, 0, "R8 no trap idle");
    step(0, 0, 1, 6'h02, "R8 other class masked");
    step(0, 0, 1, 6'h01, "R8 matching class traps");
    step(1, 32'h0000_9F80, 1, 6'h10, "R10 load+report");
    step(0, 0, 0, 0, "R10 result");
    step(1, 32'h0004_0000, 1, 6'h08, "R10 fault+report");
    step(0, 0, 0, 0, "R10 fault result");
    step(1, 32'h0000_0000, 1, 6'h3F, "R10 unmask all");
    step(0, 0, 0, 0, "R2 flags cleared by load? no, reported");
    step(1, 32'h0000_0000, 0, 0, "R2 clear by load");

    for (int n = 0; n < 400; n++) begin
      logic [31:0] d;
      d = $urandom;
      if ($urandom_range(0, 3) != 0) d[31:16] = 0;
      step($urandom_range(0, 2) == 0, d, $urandom_range(0, 1) == 1,
           6'($urandom), "random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule